// File: doc/BRIEF.md
# Power-of-Two SPI Rate Selector

This block picks the SPI serial clock rate for a controller whose clock divider only offers ratios of two times a power of two. Given the reference clock frequency and the frequency a peripheral asks for, both as integers in hertz, it searches a 3-bit divider code, one candidate per clock after a start pulse. It settles on the fastest achievable rate that does not exceed the request, and reports the code together with the rate it yields.

From that rate the block derives the receive-capture timing controls a fast SPI receiver needs. These are a tap-delay bypass, a loopback capture enable with its delay field, and a data-delay enable with its adjust value. Each is chosen by which frequency band the achieved rate falls in. Once a code has settled, the block also runs a divided clock enable that toggles a serial clock level with an exact 50% duty cycle. The block is clocked by the reference clock itself.

Top module: `spi_rate_sel`

## Requirements
- R1: The reported rate equals the latched reference divided by 2 shifted left by the code (`ref_hz >> (code + 1)`), code 0..7, so the divide ratio spans 2 to 256.
- R2: For a nonzero request the code is the smallest value whose rate is at or below the request.
- R3: A request of zero selects code 2.
- R4: When even code 7 gives a rate above a nonzero request, code 2 is selected.
- R5: A request above the reference is clamped to the reference before the search, so it yields code 0.
- R6: With `start` sampled at one rising edge, `busy` is high from the next cycle and `done` rises after (code + 1) further edges. For the zero request that is 1 edge, and for the fallback of R4 it is 8 edges.
- R7: A `start` pulse while `busy` is high is ignored and does not change the search in progress.
- R8: A rate below 40 MHz sets `tap_bypass` only; `lpbk_en`, `lpbk_dly`, `data_dly_en` and `data_dly_adj` are 0.
- R9: A rate from 40 MHz to 100 MHz inclusive sets `tap_bypass`, `lpbk_en`, `data_dly_en` and `data_dly_adj = 2`, with `lpbk_dly = 0`.
- R10: A rate above 100 MHz up to 150 MHz inclusive sets `lpbk_en` and `lpbk_dly = 3`, with `tap_bypass`, `data_dly_en` and `data_dly_adj` at 0.
- R11: A rate above 150 MHz, and the state before any search has completed, drive all five delay outputs to 0.
- R12: After a search completes, `sclk` is high for exactly `1 << code` cycles and low for exactly `1 << code` cycles, and `sclk_en` is high in exactly the cycles in which `sclk` has just changed.
- R13: `done` is a one-cycle pulse. After reset, `code`, `rate_hz`, `sclk`, `sclk_en`, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; sampled only when idle |
| ref_hz | input | 32 | Reference clock frequency in Hz |
| req_hz | input | 32 | Requested SPI frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the code has settled |
| code | output | 3 | Selected divider code |
| rate_hz | output | 32 | Achieved SPI frequency in Hz |
| sclk | output | 1 | Divided serial clock level |
| sclk_en | output | 1 | High in the cycle after each sclk change |
| tap_bypass | output | 1 | Receive tap-delay bypass |
| lpbk_en | output | 1 | Loopback capture enable |
| lpbk_dly | output | 2 | Loopback delay field |
| data_dly_en | output | 1 | Receive data-delay enable |
| data_dly_adj | output | 3 | Receive data-delay adjust value |

## Verification
The bench builds the block with its default parameters: 32-bit frequencies, a 3-bit code, default code 2, and band edges of 40, 100 and 150 MHz. With these values, reference and request pairs reach every band edge exactly, the deepest code 7 (ratio 256), the fallback after eight fruitless steps, and the clamp of an all-ones request. The duty measurement runs at codes 0, 1, 4 and 7, so half periods from one cycle up to 128 cycles are covered.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

    typedef enum logic [0:0] {
        SRCH_IDLE,
        SRCH_RUN
    } srch_state_e;

endpackage

// File: rtl/spi_rate_search.sv
module spi_rate_search
    import spi_rate_pkg::*;
#(
    parameter int FREQ_W       = 32,
    parameter int CODE_W       = 3,
    parameter int DEFAULT_CODE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] ref_hz,
    input  logic [FREQ_W-1:0] req_hz,
    output logic              busy,
    output logic              done,
    output logic              valid,
    output logic [CODE_W-1:0] code,
    output logic [FREQ_W-1:0] rate_hz
);

    localparam int MAX_CODE = (1 << CODE_W) - 1;

    typedef struct packed {
        srch_state_e       state;
        logic [FREQ_W-1:0] ref_f;
        logic [FREQ_W-1:0] req_f;
        logic [CODE_W-1:0] cand;
        logic [CODE_W-1:0] code;
        logic [FREQ_W-1:0] rate;
        logic              done;
        logic              valid;
    } srch_t;

    srch_t s_d, s_q;

    always_comb begin
        logic [FREQ_W-1:0] trial;
        logic [CODE_W-1:0] pick;
        logic              fin;
        s_d      = s_q;
        s_d.done = 1'b0;
        trial    = (s_q.ref_f >> s_q.cand) >> 1;
        pick     = s_q.cand;
        fin      = 1'b0;
        case (s_q.state)
            SRCH_IDLE: begin
                if (start) begin
                    s_d.state = SRCH_RUN;
                    s_d.ref_f = ref_hz;
                    s_d.req_f = (req_hz > ref_hz) ? ref_hz : req_hz;
                    s_d.cand  = '0;
                end
            end
            SRCH_RUN: begin
                if (s_q.req_f == '0) begin
                    pick = CODE_W'(DEFAULT_CODE);
                    fin  = 1'b1;
                end else if (trial <= s_q.req_f) begin
                    pick = s_q.cand;
                    fin  = 1'b1;
                end else if (s_q.cand == CODE_W'(MAX_CODE)) begin
                    pick = CODE_W'(DEFAULT_CODE);
                    fin  = 1'b1;
                end else begin
                    s_d.cand = s_q.cand + 1'b1;
                end
            end
            default: s_d.state = SRCH_IDLE;
        endcase
        if (fin) begin
            s_d.state = SRCH_IDLE;
            s_d.code  = pick;
            s_d.rate  = (s_q.ref_f >> pick) >> 1;
            s_d.done  = 1'b1;
            s_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: SRCH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.state == SRCH_RUN);
    assign done    = s_q.done;
    assign valid   = s_q.valid;
    assign code    = s_q.code;
    assign rate_hz = s_q.rate;

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (s_q.state == SRCH_IDLE));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == SRCH_RUN) |=> ($stable(s_q.req_f) && $stable(s_q.ref_f)));

    // R2
    minimal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && s_q.req_f != '0 && s_q.code != '0 && s_q.rate <= s_q.req_f)
        |-> ((s_q.ref_f >> s_q.code) > s_q.req_f));

endmodule

// File: rtl/spi_rate_band.sv
module spi_rate_band #(
    parameter int          FREQ_W       = 32,
    parameter int          DLY_W        = 2,
    parameter int          ADJ_W        = 3,
    parameter logic [31:0] BAND_LO_HZ   = 32'd40_000_000,
    parameter logic [31:0] BAND_MID_HZ  = 32'd100_000_000,
    parameter logic [31:0] BAND_HI_HZ   = 32'd150_000_000,
    parameter int          LPBK_DLY_VAL = 3,
    parameter int          DATA_ADJ_VAL = 2
) (
    input  logic              valid,
    input  logic [FREQ_W-1:0] rate_hz,
    output logic              tap_bypass,
    output logic              lpbk_en,
    output logic [DLY_W-1:0]  lpbk_dly,
    output logic              data_dly_en,
    output logic [ADJ_W-1:0]  data_dly_adj
);

    localparam logic [FREQ_W-1:0] LO_F  = FREQ_W'(BAND_LO_HZ);
    localparam logic [FREQ_W-1:0] MID_F = FREQ_W'(BAND_MID_HZ);
    localparam logic [FREQ_W-1:0] HI_F  = FREQ_W'(BAND_HI_HZ);

    always_comb begin
        tap_bypass   = 1'b0;
        lpbk_en      = 1'b0;
        lpbk_dly     = '0;
        data_dly_en  = 1'b0;
        data_dly_adj = '0;
        if (valid) begin
            if (rate_hz < LO_F) begin
                tap_bypass = 1'b1;
            end else if (rate_hz <= MID_F) begin
                tap_bypass   = 1'b1;
                lpbk_en      = 1'b1;
                data_dly_en  = 1'b1;
                data_dly_adj = ADJ_W'(DATA_ADJ_VAL);
            end else if (rate_hz <= HI_F) begin
                lpbk_en  = 1'b1;
                lpbk_dly = DLY_W'(LPBK_DLY_VAL);
            end
        end
    end

endmodule

// File: rtl/spi_rate_clkgen.sv
module spi_rate_clkgen #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              sclk,
    output logic              tick
);

    localparam int MAX_CODE = (1 << CODE_W) - 1;
    localparam int CNT_W    = MAX_CODE + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
        logic             tick;
    } gen_t;

    gen_t g_d, g_q;
    logic [CNT_W-1:0] half_m1;

    assign half_m1 = (CNT_W'(1) << code) - 1'b1;

    always_comb begin
        g_d      = g_q;
        g_d.tick = 1'b0;
        if (restart) begin
            g_d.cnt  = '0;
            g_d.sclk = 1'b0;
        end else if (run) begin
            if (g_q.cnt >= half_m1) begin
                g_d.cnt  = '0;
                g_d.sclk = ~g_q.sclk;
                g_d.tick = 1'b1;
            end else begin
                g_d.cnt = g_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign sclk = g_q.sclk;
    assign tick = g_q.tick;

    // R12
    tick_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.tick |-> (g_q.sclk != $past(g_q.sclk)));

    // R12
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !$past(restart)) |-> (g_q.cnt <= half_m1));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!g_q.tick && !g_q.sclk));

endmodule

// File: rtl/spi_rate_sel.sv
module spi_rate_sel #(
    parameter int          FREQ_W       = 32,
    parameter int          CODE_W       = 3,
    parameter int          DEFAULT_CODE = 2,
    parameter int          DLY_W        = 2,
    parameter int          ADJ_W        = 3,
    parameter logic [31:0] BAND_LO_HZ   = 32'd40_000_000,
    parameter logic [31:0] BAND_MID_HZ  = 32'd100_000_000,
    parameter logic [31:0] BAND_HI_HZ   = 32'd150_000_000,
    parameter int          LPBK_DLY_VAL = 3,
    parameter int          DATA_ADJ_VAL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] ref_hz,
    input  logic [FREQ_W-1:0] req_hz,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] code,
    output logic [FREQ_W-1:0] rate_hz,
    output logic              sclk,
    output logic              sclk_en,
    output logic              tap_bypass,
    output logic              lpbk_en,
    output logic [DLY_W-1:0]  lpbk_dly,
    output logic              data_dly_en,
    output logic [ADJ_W-1:0]  data_dly_adj
);

    logic valid;

    spi_rate_search #(
        .FREQ_W      (FREQ_W),
        .CODE_W      (CODE_W),
        .DEFAULT_CODE(DEFAULT_CODE)
    ) search_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .ref_hz (ref_hz),
        .req_hz (req_hz),
        .busy   (busy),
        .done   (done),
        .valid  (valid),
        .code   (code),
        .rate_hz(rate_hz)
    );

    spi_rate_band #(
        .FREQ_W      (FREQ_W),
        .DLY_W       (DLY_W),
        .ADJ_W       (ADJ_W),
        .BAND_LO_HZ  (BAND_LO_HZ),
        .BAND_MID_HZ (BAND_MID_HZ),
        .BAND_HI_HZ  (BAND_HI_HZ),
        .LPBK_DLY_VAL(LPBK_DLY_VAL),
        .DATA_ADJ_VAL(DATA_ADJ_VAL)
    ) band_i (
        .valid       (valid),
        .rate_hz     (rate_hz),
        .tap_bypass  (tap_bypass),
        .lpbk_en     (lpbk_en),
        .lpbk_dly    (lpbk_dly),
        .data_dly_en (data_dly_en),
        .data_dly_adj(data_dly_adj)
    );

    spi_rate_clkgen #(
        .CODE_W(CODE_W)
    ) clkgen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (valid),
        .restart(done),
        .code   (code),
        .sclk   (sclk),
        .tick   (sclk_en)
    );

    // R9
    mid_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_dly_en |-> (tap_bypass && lpbk_en && lpbk_dly == '0
                         && data_dly_adj == ADJ_W'(DATA_ADJ_VAL)));

    // R10
    fast_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk_dly != '0) |-> (lpbk_en && !tap_bypass && !data_dly_en));

    // R11
    idle_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (!tap_bypass && !lpbk_en && !data_dly_en));

    // R1
    rate_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rate_hz) && $stable(code)));

endmodule

// File: tb/spi_rate_sel_tb.sv
module spi_rate_sel_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CODE   = 7;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ref_hz = '0;
    logic [31:0] req_hz = '0;
    logic        busy, done, sclk, sclk_en;
    logic [2:0]  code;
    logic [31:0] rate_hz;
    logic        tap_bypass, lpbk_en, data_dly_en;
    logic [1:0]  lpbk_dly;
    logic [2:0]  data_dly_adj;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_rate_sel dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz), .req_hz(req_hz),
        .busy(busy), .done(done), .code(code), .rate_hz(rate_hz),
        .sclk(sclk), .sclk_en(sclk_en), .tap_bypass(tap_bypass),
        .lpbk_en(lpbk_en), .lpbk_dly(lpbk_dly), .data_dly_en(data_dly_en),
        .data_dly_adj(data_dly_adj)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // Band expectation packed as {bypass, lpbk, lpbk_dly[1:0], ddly_en, adj[2:0]}
    function automatic logic [7:0] exp_band(input logic [31:0] r);
        if (r < 32'd40_000_000)       return {1'b1, 1'b0, 2'd0, 1'b0, 3'd0};
        else if (r <= 32'd100_000_000) return {1'b1, 1'b1, 2'd0, 1'b1, 3'd2};
        else if (r <= 32'd150_000_000) return {1'b0, 1'b1, 2'd3, 1'b0, 3'd0};
        else                           return 8'd0;
    endfunction

    function automatic logic [7:0] act_band();
        return {tap_bypass, lpbk_en, lpbk_dly, data_dly_en, data_dly_adj};
    endfunction

    // Runs one search and checks latency, code, rate, band and the done pulse.
    task automatic run_search(input logic [31:0] rf, input logic [31:0] rq,
                              input int exp_code, input int exp_lat, input string tag);
        int lat;
        logic [31:0] exp_rate;
        @(negedge clk);
        ref_hz = rf;
        req_hz = rq;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        check(busy == 1'b1, {tag, " R6 busy"}, busy, 1);
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        exp_rate = (rf >> exp_code) >> 1;
        check(lat == exp_lat, {tag, " R6 latency"}, lat, exp_lat);
        check(code == 3'(exp_code), {tag, " R2 code"}, code, exp_code);
        check(rate_hz == exp_rate, {tag, " R1 rate"}, rate_hz, exp_rate);
        check(act_band() == exp_band(exp_rate), {tag, " R8 R9 R10 R11 band"},
              act_band(), exp_band(exp_rate));
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, {tag, " R13 done pulse"}, done, 0);
    endtask

    // Measures sclk runs after a settled code; each full run must be 1<<code.
    task automatic check_duty(input int c, input string tag);
        int half;
        int runlen;
        int nruns;
        int bad;
        int tick_bad;
        logic prev;
        half = 1 << c;
        prev = sclk;
        runlen = 1;
        nruns = 0;
        bad = 0;
        tick_bad = 0;
        for (int i = 0; i < 6 * half + 8; i++) begin
            @(negedge clk);
            if (nruns >= 1 && ((sclk != prev) != sclk_en)) tick_bad++;
            if (sclk == prev) begin
                runlen++;
            end else begin
                if (nruns >= 1 && runlen != half) bad++;
                nruns++;
                prev = sclk;
                runlen = 1;
            end
        end
        check(bad == 0 && nruns >= 4, {tag, " R12 half period"}, bad, 0);
        check(tick_bad == 0, {tag, " R12 tick alignment"}, tick_bad, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(done == 0 && busy == 0, "R13 reset handshake", {done, busy}, 0);
        check(code == 0 && rate_hz == 0, "R13 reset code/rate", rate_hz, 0);
        check(sclk == 0 && sclk_en == 0, "R13 reset sclk", {sclk, sclk_en}, 0);
        check(act_band() == 8'd0, "R11 reset band", act_band(), 0);
    endtask

    task automatic t_mid_band();
        run_search(32'd300_000_000, 32'd100_000_000, 1, 3, "mid code1 R9");
        check_duty(1, "code1");
    endtask

    task automatic t_fast_band();
        run_search(32'd300_000_000, 32'd150_000_000, 0, 2, "fast code0 R10");
        check_duty(0, "code0");
    endtask

    task automatic t_slow_band();
        run_search(32'd200_000_000, 32'd10_000_000, 4, 6, "slow code4 R8");
        check_duty(4, "code4");
    endtask

    task automatic t_max_ratio();
        run_search(32'd256_000_000, 32'd1_000_000, 7, 9, "ratio256 R1");
        check_duty(7, "code7");
    endtask

    task automatic t_fallback();
        run_search(32'd200_000_000, 32'd100, 2, MAX_CODE + 2, "fallback R4");
    endtask

    task automatic t_zero_req();
        run_search(32'd300_000_000, 32'd0, 2, 2, "zero request R3");
    endtask

    task automatic t_clamp();
        run_search(32'd400_000_000, 32'hFFFF_FFFF, 0, 2, "clamp R5 off band R11");
    endtask

    task automatic t_edges();
        run_search(32'd80_000_000, 32'd40_000_000, 0, 2, "40MHz edge R9");
        run_search(32'd200_000_000, 32'd100_000_000, 0, 2, "100MHz edge R9");
        run_search(32'd300_000_000, 32'd149_999_999, 1, 3, "below 150MHz R2");
    endtask

    task automatic t_busy_ignore();
        int lat;
        @(negedge clk);
        ref_hz = 32'd200_000_000;
        req_hz = 32'd10_000_000;
        start  = 1'b1;
        @(negedge clk);
        req_hz = 32'd100_000_000;
        ref_hz = 32'd80_000_000;
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        lat++;
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 6, "R7 latency under busy start", lat, 6);
        check(code == 3'd4, "R7 code unaffected", code, 4);
        check(rate_hz == 32'd6_250_000, "R7 rate unaffected", rate_hz, 6_250_000);
        @(negedge clk);
        check(busy == 1'b0, "R7 no second search", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mid_band();
        t_fast_band();
        t_slow_band();
        t_max_ratio();
        t_fallback();
        t_zero_req();
        t_clamp();
        t_edges();
        t_busy_ignore();
        finish_run();
    end

endmodule